// File: doc/BRIEF.md
# Dual-Mode Watchdog Timer

This block is a supervision counter that advances on machine-cycle ticks. When the selected period passes without a restart, it requests a reset of the device. Software sets it up through an 8-bit control register. That register holds a period select, an idle-hold bit, a bit that keeps the reset pin quiet, a mode bit, a self-clearing restart bit and a run enable.

The block has two ways to run. In software mode the run enable starts and stops counting, and the restart bit clears the count. In hardware mode the restart bit and the run enable have no effect. Instead, writing the byte pair 1E hex then E1 hex to a separate key register arms the watchdog and restarts the count. After that only a reset can stop it. The count also holds during power-down, and during idle when the idle-hold bit is set. Each expiry gives a one-cycle reset request. Unless the pin-quiet bit is set, it also gives a one-cycle enable for driving the reset pin as an output.

Top module: `wdog_top`

## Requirements
- R1: After reset both outputs are 0, the control readback is 00 hex and the watchdog is not counting.
- R2: With the watchdog running and a tick on every counted cycle, `wd_rst_req` pulses for exactly one cycle after PERIOD_BASE × 2^sel counted ticks, where sel is control bits [2:0]. The count then restarts from zero, so the next pulse follows one full period later.
- R3: While `pdown` is 1 the count does not advance and no reset request is produced.
- R4: While `idle` is 1, counting stops if control bit 3 (idle hold) is 1 and goes on if it is 0.
- R5: In software mode (control bit 5 = 0), control bit 7 starts and stops counting. Clearing it freezes the count, and setting it again resumes from the frozen value.
- R6: In software mode, a control write with bit 6 = 1 clears the count to zero. Bit 6 always reads back 0.
- R7: With control bit 5 = 1, a key write of 1E hex followed by a key write of E1 hex arms the watchdog and clears the count. Readback bit 7 then shows 1 (running). Before arming it shows 0 and nothing counts.
- R8: Once armed in hardware mode, control writes cannot clear bit 5 or stop counting, and bit 6 does not clear the count.
- R9: A key byte other than E1 after 1E, or an E1 without a 1E just before it, cancels the key sequence and does not arm.
- R10: `rst_pin_oe` pulses in the same cycle as `wd_rst_req` when control bit 4 is 0, and stays 0 when bit 4 is 1.
- R11: Control readback is {running, 0, mode, pin-quiet, idle-hold, sel[2:0]} from bit 7 down to bit 0. Here running is bit 7 as written in software mode and the armed state in hardware mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Machine-cycle tick; one count step per high cycle |
| idle | input | 1 | Device is in idle |
| pdown | input | 1 | Device is in power-down |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| key_wr | input | 1 | Key register write strobe |
| key_wdata | input | 8 | Key register write data |
| ctl_rdata | output | 8 | Control register readback |
| wd_rst_req | output | 1 | One-cycle internal reset request on expiry |
| rst_pin_oe | output | 1 | One-cycle enable for driving the reset pin high |

## Verification
The bench aims at expiry cycle counts: a counter that is off by one, or one that does not clear after firing, shows up as a pulse in the wrong cycle. It freezes the count with the enable, with power-down and with idle hold, and then checks the remaining cycles to expiry. A design that resets the count on disable, or that keeps counting in idle, would fire early or late. In hardware mode it tries to stop, exit and restart the watchdog through the control register. A design that honours those writes would either stop firing or fire late. Broken and out-of-order key sequences are sent as well, so a design that arms on E1 alone, or that remembers 1E past a wrong byte, changes the readback.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int SEL_W = 3;

  localparam int B_IDLE = 3;
  localparam int B_PIN  = 4;
  localparam int B_HW   = 5;
  localparam int B_RST  = 6;
  localparam int B_EN   = 7;

  localparam logic [7:0] KEY_FIRST  = 8'h1E;
  localparam logic [7:0] KEY_SECOND = 8'hE1;

  typedef struct packed {
    logic             running;
    logic             restart;
    logic             hw_mode;
    logic             pin_quiet;
    logic             idle_hold;
    logic [SEL_W-1:0] sel;
  } ctl_view_t;

  // last count value before expiry: base * 2^sel - 1
  function automatic int unsigned last_count(int unsigned base, logic [SEL_W-1:0] sel);
    return (base << sel) - 1;
  endfunction

endpackage

// File: rtl/wdog_key.sv
module wdog_key
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_wdata,
  input  logic       hw_mode,
  output logic       armed,
  output logic       key_hit
);

  logic seen_first;

  assign key_hit = key_wr && seen_first && (key_wdata == KEY_SECOND) && hw_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_first <= 1'b0;
      armed      <= 1'b0;
    end else begin
      if (key_wr) seen_first <= (key_wdata == KEY_FIRST);
      if (key_hit) armed <= 1'b1;
    end
  end

  // R7
  arm_follows_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |=> armed);

  // R9
  arm_only_by_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(key_wr) && ($past(key_wdata) == KEY_SECOND));

endmodule

// File: rtl/wdog_ctl.sv
module wdog_ctl
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [7:0]       ctl_wdata,
  input  logic             armed,
  output logic [SEL_W-1:0] sel,
  output logic             idle_hold,
  output logic             pin_quiet,
  output logic             hw_mode,
  output logic             run_en,
  output logic             sw_clr,
  output logic [7:0]       ctl_rdata
);

  logic      sw_en;
  logic      hw_locked;
  ctl_view_t view;

  assign hw_locked = hw_mode && armed;
  assign sw_clr    = ctl_wr && ctl_wdata[B_RST] && !hw_mode;
  assign run_en    = hw_mode ? armed : sw_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel       <= '0;
      idle_hold <= 1'b0;
      pin_quiet <= 1'b0;
      hw_mode   <= 1'b0;
      sw_en     <= 1'b0;
    end else if (ctl_wr) begin
      sel       <= ctl_wdata[SEL_W-1:0];
      idle_hold <= ctl_wdata[B_IDLE];
      pin_quiet <= ctl_wdata[B_PIN];
      sw_en     <= ctl_wdata[B_EN];
      if (!hw_locked) hw_mode <= ctl_wdata[B_HW];
    end
  end

  always_comb begin
    view.running   = run_en;
    view.restart   = 1'b0;
    view.hw_mode   = hw_mode;
    view.pin_quiet = pin_quiet;
    view.idle_hold = idle_hold;
    view.sel       = sel;
  end
  assign ctl_rdata = view;

  // R8
  hw_mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_mode && armed) |=> hw_mode);

endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int unsigned PERIOD_BASE = 16384,
  parameter int          CNT_W       = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             idle,
  input  logic             pdown,
  input  logic             idle_hold,
  input  logic             pin_quiet,
  input  logic             run_en,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             wd_rst_req,
  output logic             rst_pin_oe
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic             active;
  logic             step;
  logic             expire;

  assign last   = CNT_W'(last_count(PERIOD_BASE, sel));
  assign active = run_en && !pdown && !(idle && idle_hold);
  assign step   = tick && active;
  assign expire = step && (cnt == last) && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      wd_rst_req <= 1'b0;
      rst_pin_oe <= 1'b0;
    end else begin
      if (clr || expire) cnt <= '0;
      else if (step)     cnt <= cnt + 1'b1;
      wd_rst_req <= expire;
      rst_pin_oe <= expire && !pin_quiet;
    end
  end

  // R2
  req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_req |=> !wd_rst_req);

  // R3
  pdown_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pdown && !clr) |=> $stable(cnt));

  // R6
  clear_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  // R10
  pin_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pin_oe |-> wd_rst_req);

endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int unsigned PERIOD_BASE = 16384
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       idle,
  input  logic       pdown,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  input  logic       key_wr,
  input  logic [7:0] key_wdata,
  output logic [7:0] ctl_rdata,
  output logic       wd_rst_req,
  output logic       rst_pin_oe
);

  localparam int CNT_W = $clog2(PERIOD_BASE) + (1 << SEL_W) - 1;

  logic [SEL_W-1:0] sel;
  logic             idle_hold;
  logic             pin_quiet;
  logic             hw_mode;
  logic             run_en;
  logic             sw_clr;
  logic             armed;
  logic             key_hit;
  logic             cnt_clr;

  assign cnt_clr = sw_clr || key_hit;

  wdog_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .armed     (armed),
    .sel       (sel),
    .idle_hold (idle_hold),
    .pin_quiet (pin_quiet),
    .hw_mode   (hw_mode),
    .run_en    (run_en),
    .sw_clr    (sw_clr),
    .ctl_rdata (ctl_rdata)
  );

  wdog_key u_key (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_wr    (key_wr),
    .key_wdata (key_wdata),
    .hw_mode   (hw_mode),
    .armed     (armed),
    .key_hit   (key_hit)
  );

  wdog_count #(
    .PERIOD_BASE (PERIOD_BASE),
    .CNT_W       (CNT_W)
  ) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .idle       (idle),
    .pdown      (pdown),
    .idle_hold  (idle_hold),
    .pin_quiet  (pin_quiet),
    .run_en     (run_en),
    .clr        (cnt_clr),
    .sel        (sel),
    .wd_rst_req (wd_rst_req),
    .rst_pin_oe (rst_pin_oe)
  );

  // R7
  running_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_mode && ctl_rdata[B_EN]) |-> armed);

endmodule

// File: tb/wdog_top_bench.sv
module wdog_top_bench;

  localparam int BASE = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       idle = 1'b0;
  logic       pdown = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic       key_wr = 1'b0;
  logic [7:0] key_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic       wd_rst_req;
  logic       rst_pin_oe;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  wdog_top #(.PERIOD_BASE(BASE)) u_wdog_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .idle       (idle),
    .pdown      (pdown),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (ctl_wdata),
    .key_wr     (key_wr),
    .key_wdata  (key_wdata),
    .ctl_rdata  (ctl_rdata),
    .wd_rst_req (wd_rst_req),
    .rst_pin_oe (rst_pin_oe)
  );

  always #5 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // behavioural reference model, one update per clock
  int   m_cnt, m_sel, m_period;
  bit   m_en, m_hw, m_armed, m_seen, m_idleh, m_pinq, m_req, m_pin;
  bit   m_run, m_act, m_clr, m_fire, o_hw, o_armed;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_sel = 0; m_en = 0; m_hw = 0; m_armed = 0; m_seen = 0;
      m_idleh = 0; m_pinq = 0; m_req = 0; m_pin = 0;
    end else begin
      o_hw = m_hw; o_armed = m_armed;
      m_period = BASE * (2 ** m_sel);
      m_run = o_hw ? o_armed : m_en;
      m_act = m_run && !pdown && !(idle && m_idleh);
      m_clr = (ctl_wr && ctl_wdata[6] && !o_hw) ||
              (key_wr && key_wdata == 8'hE1 && m_seen && o_hw);
      m_fire = tick && m_act && !m_clr && (m_cnt == m_period - 1);
      m_req = m_fire;
      m_pin = m_fire && !m_pinq;
      if (m_clr || m_fire) m_cnt = 0;
      else if (tick && m_act) m_cnt++;
      if (key_wr) begin
        if (o_hw && m_seen && key_wdata == 8'hE1) m_armed = 1;
        m_seen = (key_wdata == 8'h1E);
      end
      if (ctl_wr) begin
        m_sel = ctl_wdata[2:0]; m_idleh = ctl_wdata[3]; m_pinq = ctl_wdata[4];
        m_en = ctl_wdata[7];
        if (!(o_hw && o_armed)) m_hw = ctl_wdata[5];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 model reset request", wd_rst_req, m_req);
      chk("R10 model pin enable", rst_pin_oe, m_pin);
      chk("R11 model readback", ctl_rdata,
          {m_hw ? m_armed : m_en, 1'b0, m_hw, m_pinq, m_idleh, 3'(m_sel)});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      report();
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; tick = 1; idle = 0; pdown = 0; ctl_wr = 0; key_wr = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr_ctl(logic [7:0] d);
    ctl_wr = 1; ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 0;
  endtask

  task automatic wr_key(logic [7:0] d);
    key_wr = 1; key_wdata = d;
    @(negedge clk);
    key_wr = 0;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic to_pulse(int max, output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!wd_rst_req && k < max);
  endtask

  task automatic quiet(int n, output int seen);
    seen = 0;
    repeat (n) begin
      @(negedge clk);
      if (wd_rst_req) seen++;
    end
  endtask

  initial begin
    int k, s;
    do_reset();
    @(negedge clk);
    chk("R1 req after reset", wd_rst_req, 0);
    chk("R1 pin after reset", rst_pin_oe, 0);
    chk("R1 readback after reset", ctl_rdata, 8'h00);
    quiet(40, s);
    chk("R1 idle after reset", s, 0);

    // R11 field layout
    wr_ctl(8'h1D);
    chk("R11 readback layout", ctl_rdata, 8'h1D);

    // R2 / R10 software mode sel 0
    do_reset();
    wr_ctl(8'h80);
    to_pulse(100, k);
    chk("R2 first expiry", k, 16);
    chk("R10 pin drives", rst_pin_oe, 1);
    @(negedge clk);
    chk("R2 one cycle pulse", wd_rst_req, 0);
    to_pulse(100, k);
    chk("R2 count cleared after expiry", k, 15);

    // R2 sel 2 with pin quiet, restart in the same write
    wr_ctl(8'hD2);
    to_pulse(200, k);
    chk("R2 sel 2 period", k, 64);
    chk("R10 pin quiet", rst_pin_oe, 0);

    // R2 gapped ticks, checked by the model
    wr_ctl(8'hC1);
    repeat (140) begin
      @(negedge clk);
      tick = ~tick;
    end
    tick = 1;

    // R5 freeze and resume
    do_reset();
    wr_ctl(8'hC0);
    step(5);
    wr_ctl(8'h00);
    quiet(20, s);
    chk("R5 disabled no pulse", s, 0);
    wr_ctl(8'h80);
    to_pulse(100, k);
    chk("R5 resumes frozen count", k, 10);

    // R4 idle
    do_reset();
    idle = 1;
    wr_ctl(8'hC8);
    quiet(40, s);
    chk("R4 idle hold stops", s, 0);
    wr_ctl(8'hC0);
    to_pulse(100, k);
    chk("R4 idle counts without hold", k, 16);
    idle = 0;

    // R3 power-down
    do_reset();
    wr_ctl(8'hC0);
    pdown = 1;
    quiet(40, s);
    chk("R3 power-down stops", s, 0);
    pdown = 0;
    to_pulse(100, k);
    chk("R3 resumes after power-down", k, 16);

    // R6 software restart
    do_reset();
    wr_ctl(8'hC0);
    step(10);
    wr_ctl(8'hC0);
    chk("R6 restart bit reads 0", ctl_rdata[6], 0);
    to_pulse(100, k);
    chk("R6 restart clears count", k, 16);

    // R7 / R8 hardware mode
    do_reset();
    wr_ctl(8'h20);
    chk("R7 not armed readback", ctl_rdata, 8'h20);
    quiet(40, s);
    chk("R7 not armed no pulse", s, 0);
    wr_key(8'h1E);
    wr_key(8'hE1);
    chk("R7 armed readback", ctl_rdata, 8'hA0);
    to_pulse(100, k);
    chk("R7 armed expiry", k, 16);
    wr_ctl(8'h00);
    chk("R8 mode sticky", ctl_rdata, 8'hA0);
    step(4);
    wr_ctl(8'h40);
    to_pulse(100, k);
    chk("R8 restart bit ignored", k, 10);

    // R9 broken sequences
    do_reset();
    wr_ctl(8'h20);
    wr_key(8'h1E);
    wr_key(8'h55);
    wr_key(8'hE1);
    chk("R9 wrong byte cancels", ctl_rdata, 8'h20);
    wr_key(8'hE1);
    chk("R9 lone second byte", ctl_rdata, 8'h20);
    wr_key(8'h1E);
    wr_key(8'hE1);
    chk("R9 good sequence arms", ctl_rdata, 8'hA0);
    do_reset();
    @(negedge clk);
    chk("R1 reset disarms", ctl_rdata, 8'h00);

    report();
  end

endmodule